// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block is the embedded controller that carries out byte programming, whole-array erase and multi-sector erase for a flash array split into eight equal sectors. A command decoder in front of it turns bus write sequences into single-cycle pulses: program, chip erase, sector select, suspend, resume and reset. Each pulse comes with the bus address and data. The sequencer then drives a simple array port. On that port it issues one request at a time, either a byte program or an erase of one sector, and it waits for the array's done pulse and fail flag.

Sector selection for a block erase stays open for an acceptance window. Every new select restarts that window. When the window expires, erasing begins and no more sectors can join. Protection arrives as a static per-sector mask, and protected sectors are skipped without any error. An operation whose every target is protected still runs a short dummy busy period. A block erase can be suspended and resumed any number of times, and a reset aborts it after an abort interval. Every delay is a parameter counted in clock cycles.

The status logic reads the busy, erase-started, suspended and error flags, along with the pending-sector and failed-sector masks.

Top module: `flash_pe_seq`

## Requirements
- R1: A program pulse whose address lies in an unprotected sector does three things: it raises `arr_prog_req` with the latched address and data, it holds `busy` high until `arr_done`, and it then returns to idle with no error. The sector number is address bits [18:16].
- R2: A program pulse aimed at a protected sector is dropped. No busy cycle follows, no array request is made and no error is raised.
- R3: Erasing begins exactly WIN_CYC cycles after the last sector-select pulse. Each select pulse made during the window restarts the count.
- R4: In `pending_mask`, bit i stands for sector i. The mask collects the unprotected selected sectors, and protected selects add nothing. Each pending sector is erased exactly once, lowest index first. Skipped sectors raise no error.
- R5: After `erase_started` rises, further sector-select pulses leave `pending_mask` unchanged and are never erased.
- R6: If every target sector is protected, `erase_started` still rises. `busy` then stays high for DUMMY_CYC cycles after the window (or after the chip-erase pulse), with no array request and no error.
- R7: While a program or a chip erase runs, every command pulse is ignored, including suspend and reset.
- R8: A suspend during the acceptance window takes effect in the next cycle. The block is then suspended, not busy and has not started erasing. Selects made while suspended are ignored. Resume begins erasing in the next cycle.
- R9: A suspend during block erasing makes `suspended` rise SUSP_CYC cycles later, and no array request is made while suspended. Resume reissues the interrupted sector. Suspend and resume can be repeated.
- R10: An array failure sets `error` and the sector's bit in `fail_mask`. Both hold, and all commands except reset are ignored, until a reset pulse. Reset gives ABORT_CYC busy cycles, then idle with both masks clear.
- R11: A reset during a block erase (window, erasing or suspended) stops all array requests at once. `busy` then falls ABORT_CYC cycles later and `pending_mask` clears.
- R12: After `rst_n` is released, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_prog | input | 1 | Program command pulse |
| cmd_chip | input | 1 | Chip erase command pulse |
| cmd_blk | input | 1 | Sector select (block erase) pulse |
| cmd_susp | input | 1 | Erase suspend pulse |
| cmd_resume | input | 1 | Erase resume pulse |
| cmd_reset | input | 1 | Reset/abort command pulse |
| cmd_addr | input | ADDR_W | Address accompanying the command |
| cmd_data | input | DATA_W | Data accompanying a program command |
| prot_mask | input | N_SECT | Static per-sector protection |
| arr_done | input | 1 | Array finished the current request (one cycle) |
| arr_fail | input | 1 | Failure flag, valid with arr_done |
| arr_prog_req | output | 1 | Byte program request |
| arr_prog_addr | output | ADDR_W | Address to program |
| arr_prog_data | output | DATA_W | Data to program |
| arr_erase_req | output | 1 | Sector erase request |
| arr_erase_sec | output | SEC_W | Sector being erased |
| busy | output | 1 | Operation, window, dummy or abort in progress |
| erase_started | output | 1 | Erasing has begun, no more selects taken |
| suspended | output | 1 | Erase is suspended |
| error | output | 1 | Failure latched until reset |
| pending_mask | output | N_SECT | Sectors still to erase |
| fail_mask | output | N_SECT | Sectors that failed |

## Verification
Block erase is exercised with several sector-select patterns. These include a mix of protected and unprotected sectors, selects arriving in descending order and late selects after erasing begins. Together they separate the collection of selects, the lowest-first ordering and the freeze on selects. Erase is also run with every target protected, comparing chip erase against block erase, which shows the dummy period apart from real array activity. Suspend is issued both inside the window and mid-erase, and a second time after a resume, so the immediate path and the latency path are measured against SUSP_CYC. Reset is applied during the window, during erasing and after an injected failure, while suspend and reset are applied during program and chip erase, which confirms where each command is honoured.

// File: rtl/flash_pe_pkg.sv
`timescale 1ns/1ps
// Shared types for the flash program/erase sequencer.
package flash_pe_pkg;
    // Controller states.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG,
        ST_WINDOW,
        ST_ERASE,
        ST_SUSP_WAIT,
        ST_SUSPENDED,
        ST_DUMMY,
        ST_ABORT,
        ST_ERROR
    } seq_state_e;
endpackage

// File: rtl/fpe_cycle_timer.sv
`timescale 1ns/1ps
// Down-counter shared by all timed states of the sequencer.
// Loading N-1 makes expired_o true in the N-th cycle after the load.
// Assumes the owner only looks at expired_o in a state it loaded.
module fpe_cycle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load on request, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load_i)         cnt_q <= load_val_i;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);

    // The count only moves down or is reloaded.
    p_timer_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/fpe_lowest_pick.sv
`timescale 1ns/1ps
// Picks the lowest-numbered set bit of a sector mask.
// Pure combinational; idx_o is zero when the mask is empty.
module fpe_lowest_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     mask_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);
    logic [N:0]   seen;
    logic [N-1:0] first;

    assign seen[0] = 1'b0;
    for (genvar g = 0; g < N; g++) begin : g_chain
        assign first[g]    = mask_i[g] & ~seen[g];
        assign seen[g+1]   = seen[g] | mask_i[g];
    end

    // Encode the single winning bit into an index.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (first[i]) idx_o = idx_o | IDX_W'(i);
        end
    end

    assign any_o = seen[N];

    // At most one winner at any time.
    always_comb begin
        p_one_winner_r4: assert ($onehot0(first));
    end
endmodule

// File: rtl/flash_pe_seq.sv
`timescale 1ns/1ps
// Flash program/erase sequencer.
// Takes decoded command pulses, runs byte program, chip erase and
// multi-sector erase against an array port with a req/done handshake.
// Assumes: command pulses are one cycle, prot_mask changes only while
// idle, arr_done is a one-cycle pulse that only answers a held request.
module flash_pe_seq
    import flash_pe_pkg::*;
#(
    parameter int N_SECT    = 8,
    parameter int ADDR_W    = 19,
    parameter int DATA_W    = 8,
    parameter int WIN_CYC   = 5000,
    parameter int SUSP_CYC  = 1500,
    parameter int ABORT_CYC = 1000,
    parameter int DUMMY_CYC = 10000,
    localparam int SEC_W    = $clog2(N_SECT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_prog,
    input  logic              cmd_chip,
    input  logic              cmd_blk,
    input  logic              cmd_susp,
    input  logic              cmd_resume,
    input  logic              cmd_reset,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [N_SECT-1:0] prot_mask,
    input  logic              arr_done,
    input  logic              arr_fail,
    output logic              arr_prog_req,
    output logic [ADDR_W-1:0] arr_prog_addr,
    output logic [DATA_W-1:0] arr_prog_data,
    output logic              arr_erase_req,
    output logic [SEC_W-1:0]  arr_erase_sec,
    output logic              busy,
    output logic              erase_started,
    output logic              suspended,
    output logic              error,
    output logic [N_SECT-1:0] pending_mask,
    output logic [N_SECT-1:0] fail_mask
);
    localparam int MAX_WS  = (WIN_CYC > SUSP_CYC) ? WIN_CYC : SUSP_CYC;
    localparam int MAX_AD  = (ABORT_CYC > DUMMY_CYC) ? ABORT_CYC : DUMMY_CYC;
    localparam int MAX_ALL = (MAX_WS > MAX_AD) ? MAX_WS : MAX_AD;
    localparam int CNT_W   = $clog2(MAX_ALL + 1);

    seq_state_e        state_q, state_d;
    logic [N_SECT-1:0] pending_q, pending_d, fail_q, fail_d;
    logic              chip_q, chip_d, began_q, began_d;
    logic [ADDR_W-1:0] paddr_q;
    logic [DATA_W-1:0] pdata_q;
    logic              prog_take;
    logic              tmr_load, tmr_exp;
    logic [CNT_W-1:0]  tmr_val;
    logic [SEC_W-1:0]  pick_idx;
    logic              pick_any;

    logic [SEC_W-1:0]  sel_sec, prog_sec;
    logic              sel_prot;
    logic [N_SECT-1:0] sel_bit, pick_bit, rem_mask, fail_upd;

    assign sel_sec  = cmd_addr[ADDR_W-1 -: SEC_W];
    assign prog_sec = paddr_q[ADDR_W-1 -: SEC_W];
    assign sel_prot = prot_mask[sel_sec];
    assign sel_bit  = N_SECT'(1) << sel_sec;
    assign pick_bit = N_SECT'(1) << pick_idx;
    assign rem_mask = arr_done ? (pending_q & ~pick_bit) : pending_q;
    assign fail_upd = (arr_done && arr_fail) ? (fail_q | pick_bit) : fail_q;

    fpe_lowest_pick #(.N(N_SECT), .IDX_W(SEC_W)) u_pick (
        .mask_i (pending_q),
        .idx_o  (pick_idx),
        .any_o  (pick_any)
    );

    fpe_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_exp)
    );

    // Next-state and mask update for every command and array event.
    always_comb begin
        state_d   = state_q;
        pending_d = pending_q;
        fail_d    = fail_q;
        chip_d    = chip_q;
        began_d   = began_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        prog_take = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_prog) begin
                    if (!sel_prot) begin
                        state_d   = ST_PROG;
                        prog_take = 1'b1;
                    end
                end else if (cmd_chip) begin
                    chip_d    = 1'b1;
                    began_d   = 1'b1;
                    pending_d = ~prot_mask;
                    if (~prot_mask == '0) begin
                        state_d  = ST_DUMMY;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(DUMMY_CYC - 1);
                    end else begin
                        state_d  = ST_ERASE;
                    end
                end else if (cmd_blk) begin
                    state_d   = ST_WINDOW;
                    chip_d    = 1'b0;
                    pending_d = sel_prot ? '0 : sel_bit;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(WIN_CYC - 1);
                end
            end
            ST_PROG: begin
                if (arr_done) begin
                    if (arr_fail) begin
                        state_d = ST_ERROR;
                        fail_d  = fail_q | (N_SECT'(1) << prog_sec);
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_WINDOW: begin
                if (cmd_reset) begin
                    state_d  = ST_ABORT;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(ABORT_CYC - 1);
                end else if (cmd_susp) begin
                    state_d = ST_SUSPENDED;
                end else if (cmd_blk) begin
                    if (!sel_prot) pending_d = pending_q | sel_bit;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(WIN_CYC - 1);
                end else if (tmr_exp) begin
                    began_d = 1'b1;
                    if (pending_q == '0) begin
                        state_d  = ST_DUMMY;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(DUMMY_CYC - 1);
                    end else begin
                        state_d  = ST_ERASE;
                    end
                end
            end
            ST_ERASE, ST_SUSP_WAIT: begin
                if (!chip_q && cmd_reset) begin
                    state_d  = ST_ABORT;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(ABORT_CYC - 1);
                end else begin
                    pending_d = rem_mask;
                    fail_d    = fail_upd;
                    if (rem_mask == '0) begin
                        state_d = (fail_upd != '0) ? ST_ERROR : ST_IDLE;
                    end else if (state_q == ST_ERASE && !chip_q && cmd_susp) begin
                        state_d  = ST_SUSP_WAIT;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(SUSP_CYC - 1);
                    end else if (state_q == ST_SUSP_WAIT && tmr_exp) begin
                        state_d = ST_SUSPENDED;
                    end
                end
            end
            ST_SUSPENDED: begin
                if (cmd_reset) begin
                    state_d  = ST_ABORT;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(ABORT_CYC - 1);
                end else if (cmd_resume) begin
                    began_d = 1'b1;
                    if (pending_q == '0) begin
                        state_d  = ST_DUMMY;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(DUMMY_CYC - 1);
                    end else begin
                        state_d  = ST_ERASE;
                    end
                end
            end
            ST_DUMMY: begin
                if (tmr_exp) state_d = ST_IDLE;
            end
            ST_ABORT: begin
                if (tmr_exp) state_d = ST_IDLE;
            end
            ST_ERROR: begin
                if (cmd_reset) begin
                    state_d  = ST_ABORT;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(ABORT_CYC - 1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (state_d == ST_ABORT) begin
            pending_d = '0;
            fail_d    = '0;
            began_d   = 1'b0;
        end
        if (state_d == ST_IDLE || state_d == ST_ERROR) begin
            pending_d = '0;
            began_d   = 1'b0;
            chip_d    = 1'b0;
        end
    end

    // State and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pending_q <= '0;
            fail_q    <= '0;
            chip_q    <= 1'b0;
            began_q   <= 1'b0;
        end else begin
            state_q   <= state_d;
            pending_q <= pending_d;
            fail_q    <= fail_d;
            chip_q    <= chip_d;
            began_q   <= began_d;
        end
    end

    // Program address and data latch, taken when a program is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paddr_q <= '0;
            pdata_q <= '0;
        end else if (prog_take) begin
            paddr_q <= cmd_addr;
            pdata_q <= cmd_data;
        end
    end

    assign arr_prog_req  = (state_q == ST_PROG);
    assign arr_prog_addr = paddr_q;
    assign arr_prog_data = pdata_q;
    assign arr_erase_req = (state_q == ST_ERASE || state_q == ST_SUSP_WAIT) && pick_any;
    assign arr_erase_sec = pick_idx;
    assign busy          = (state_q == ST_PROG)   || (state_q == ST_WINDOW) ||
                           (state_q == ST_ERASE)  || (state_q == ST_SUSP_WAIT) ||
                           (state_q == ST_DUMMY)  || (state_q == ST_ABORT);
    assign erase_started = began_q;
    assign suspended     = (state_q == ST_SUSPENDED);
    assign error         = (state_q == ST_ERROR);
    assign pending_mask  = pending_q;
    assign fail_mask     = fail_q;

    // One array request at a time.
    p_req_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_prog_req && arr_erase_req));
    // A program request is held until the array answers.
    p_prog_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        arr_prog_req && !arr_done |=> arr_prog_req);
    // Only pending, unprotected sectors are sent for erase.
    p_erase_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_erase_req |-> pending_mask[arr_erase_sec] && !prot_mask[arr_erase_sec]);
    // Once erasing has begun the sector list only shrinks via the array.
    p_pending_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        erase_started && !arr_done && !cmd_reset |=> $stable(pending_mask));
    // No array traffic while suspended.
    p_quiet_suspend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |-> !arr_erase_req && !arr_prog_req);
    // An error stays until a reset pulse.
    p_error_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        error && !cmd_reset |=> error && $stable(fail_mask));
    // Reset during a block erase silences the array port next cycle.
    p_reset_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset && suspended |=> !arr_erase_req && busy);
endmodule

// File: tb/flash_pe_seq_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: small timing parameters, behavioural array model.
module flash_pe_seq_tb_top;
    localparam int WIN = 8, SUSP = 4, ABRT = 5, DUMY = 6, LAT = 12;
    localparam int K_PROG = 0, K_CHIP = 1, K_BLK = 2, K_SUSP = 3, K_RES = 4, K_RST = 5;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cmd_prog = 0, cmd_chip = 0, cmd_blk = 0, cmd_susp = 0, cmd_resume = 0, cmd_reset = 0;
    logic [18:0] cmd_addr = '0;
    logic [7:0]  cmd_data = '0;
    logic [7:0]  prot = 8'h48;
    logic        arr_done, arr_fail;
    logic        arr_prog_req, arr_erase_req, busy, erase_started, suspended, error;
    logic [18:0] arr_prog_addr;
    logic [7:0]  arr_prog_data, pending_mask, fail_mask;
    logic [2:0]  arr_erase_sec;
    logic [7:0]  failset = 8'h00;

    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    flash_pe_seq #(.WIN_CYC(WIN), .SUSP_CYC(SUSP), .ABORT_CYC(ABRT), .DUMMY_CYC(DUMY)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_prog(cmd_prog), .cmd_chip(cmd_chip), .cmd_blk(cmd_blk),
        .cmd_susp(cmd_susp), .cmd_resume(cmd_resume), .cmd_reset(cmd_reset),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .prot_mask(prot),
        .arr_done(arr_done), .arr_fail(arr_fail),
        .arr_prog_req(arr_prog_req), .arr_prog_addr(arr_prog_addr), .arr_prog_data(arr_prog_data),
        .arr_erase_req(arr_erase_req), .arr_erase_sec(arr_erase_sec),
        .busy(busy), .erase_started(erase_started), .suspended(suspended), .error(error),
        .pending_mask(pending_mask), .fail_mask(fail_mask)
    );

    // Array model: answers a held request after LAT cycles, logs its work.
    int          er_cnt [8];
    int          prog_cnt = 0, req_cyc = 0;
    logic [31:0] hist = '0;
    logic [18:0] prog_a = '0;
    logic [7:0]  prog_d = '0;
    int          lat = 0;
    always @(posedge clk) begin
        if (arr_erase_req) req_cyc <= req_cyc + 1;
        if (!rst_n) begin
            arr_done <= 1'b0; arr_fail <= 1'b0; lat <= 0;
        end else if (arr_done) begin
            arr_done <= 1'b0; arr_fail <= 1'b0; lat <= 0;
        end else if (arr_erase_req || arr_prog_req) begin
            if (lat == LAT - 1) begin
                arr_done <= 1'b1;
                lat      <= 0;
                if (arr_erase_req) begin
                    arr_fail <= failset[arr_erase_sec];
                    er_cnt[arr_erase_sec] <= er_cnt[arr_erase_sec] + 1;
                    hist <= {hist[27:0], 1'b0, arr_erase_sec};
                end else begin
                    arr_fail <= 1'b0;
                    prog_cnt <= prog_cnt + 1;
                    prog_a   <= arr_prog_addr;
                    prog_d   <= arr_prog_data;
                end
            end else begin
                lat <= lat + 1;
            end
        end else begin
            lat <= 0;
        end
    end

    int base [8];
    task automatic snap();
        for (int i = 0; i < 8; i++) base[i] = er_cnt[i];
    endtask
    function automatic int delta(input int s);
        return er_cnt[s] - base[s];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [18:0] sa(input int s, input int off);
        return {3'(s), 16'(off)};
    endfunction

    task automatic pulse(input int kind, input logic [18:0] a, input logic [7:0] d);
        cmd_addr = a; cmd_data = d;
        case (kind)
            K_PROG: cmd_prog = 1'b1;
            K_CHIP: cmd_chip = 1'b1;
            K_BLK:  cmd_blk = 1'b1;
            K_SUSP: cmd_susp = 1'b1;
            K_RES:  cmd_resume = 1'b1;
            default: cmd_reset = 1'b1;
        endcase
        @(posedge clk);
        @(negedge clk);
        cmd_prog = 0; cmd_chip = 0; cmd_blk = 0; cmd_susp = 0; cmd_resume = 0; cmd_reset = 0;
    endtask

    // which: 0 busy low, 1 erase_started high, 2 suspended high
    task automatic wait_for(input int which, output int n);
        n = 0;
        while (n < 3000 && !((which == 0 && !busy) || (which == 1 && erase_started) ||
                             (which == 2 && suspended))) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin : watchdog
        #500000;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int n, rq, pc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, erase_started, suspended, error, arr_prog_req, arr_erase_req, pending_mask, fail_mask} == '0,
            "R12 reset state", {busy, erase_started, suspended, error, pending_mask}, 0);

        // R1: program unprotected sector 2
        pulse(K_PROG, sa(2, 16'h1234), 8'hA5);
        chk(busy && arr_prog_req && arr_prog_addr == sa(2, 16'h1234) && arr_prog_data == 8'hA5,
            "R1 program request", {busy, arr_prog_req, arr_prog_addr}, {2'b11, sa(2, 16'h1234)});
        wait_for(0, n);
        chk(prog_cnt == 1 && prog_a == sa(2, 16'h1234) && prog_d == 8'hA5 && !error,
            "R1 program done", prog_cnt, 1);

        // R2: program to protected sector 3 is dropped
        pulse(K_PROG, sa(3, 5), 8'h00);
        chk(!busy && !arr_prog_req && !error, "R2 no busy", {busy, arr_prog_req, error}, 0);
        repeat (LAT + 2) @(negedge clk);
        chk(prog_cnt == 1, "R2 no array write", prog_cnt, 1);

        // R3/R4: selects 5, 3 (protected), then 1 after a gap
        snap();
        pulse(K_BLK, sa(5, 0), 0);
        pulse(K_BLK, sa(3, 0), 0);
        repeat (3) @(negedge clk);
        pulse(K_BLK, sa(1, 0), 0);
        chk(pending_mask == 8'h22 && !erase_started, "R4 pending collect", pending_mask, 8'h22);
        wait_for(1, n);
        chk(n == WIN, "R3 window restart", n, WIN);
        // R5: late select ignored
        pulse(K_BLK, sa(7, 0), 0);
        chk(pending_mask == 8'h22, "R5 select after start", pending_mask, 8'h22);
        wait_for(0, n);
        chk(delta(1) == 1 && delta(5) == 1 && delta(3) == 0 && delta(7) == 0 && !error,
            "R4 R5 sectors erased", {delta(1), delta(5), delta(7)}, 0);
        chk(hist[7:0] == 8'h15, "R4 lowest first", hist[7:0], 8'h15);

        // R6: chip erase with everything protected
        prot = 8'hFF;
        snap(); rq = req_cyc;
        pulse(K_CHIP, '0, 0);
        chk(erase_started && busy, "R6 chip dummy start", {erase_started, busy}, 2'b11);
        wait_for(0, n);
        chk(n == DUMY && !error && req_cyc == rq, "R6 chip dummy length", n, DUMY);
        // R6: block erase of a protected sector
        pulse(K_BLK, sa(2, 0), 0);
        wait_for(0, n);
        chk(n == WIN + DUMY && req_cyc == rq && !error, "R6 block dummy length", n, WIN + DUMY);
        prot = 8'h48;

        // R7: select during program ignored
        snap(); rq = req_cyc; pc = prog_cnt;
        pulse(K_PROG, sa(0, 7), 8'h3C);
        pulse(K_BLK, sa(0, 0), 0);
        wait_for(0, n);
        repeat (WIN + 2) @(negedge clk);
        chk(prog_cnt == pc + 1 && req_cyc == rq && pending_mask == 0 && !busy,
            "R7 select during program", req_cyc - rq, 0);
        // R7: suspend and reset during chip erase ignored
        pulse(K_CHIP, '0, 0);
        repeat (3) @(negedge clk);
        pulse(K_SUSP, '0, 0);
        repeat (SUSP + 2) @(negedge clk);
        chk(!suspended && busy, "R7 suspend during chip erase", suspended, 0);
        pulse(K_RST, '0, 0);
        chk(busy && arr_erase_req, "R7 reset during chip erase", {busy, arr_erase_req}, 2'b11);
        wait_for(0, n);
        chk(delta(0) == 1 && delta(1) == 1 && delta(2) == 1 && delta(4) == 1 && delta(5) == 1 &&
            delta(7) == 1 && delta(3) == 0 && delta(6) == 0 && !error,
            "R7 chip erase complete", {delta(3), delta(6)}, 0);

        // R8: suspend inside window
        snap();
        pulse(K_BLK, sa(4, 0), 0);
        pulse(K_SUSP, '0, 0);
        chk(suspended && !erase_started && !busy, "R8 immediate suspend", {suspended, erase_started, busy}, 3'b100);
        repeat (WIN + 4) @(negedge clk);
        pulse(K_BLK, sa(0, 0), 0);
        chk(suspended && pending_mask == 8'h10 && delta(4) == 0, "R8 hold and ignore select", pending_mask, 8'h10);
        pulse(K_RES, '0, 0);
        chk(erase_started && arr_erase_req, "R8 resume starts erase", {erase_started, arr_erase_req}, 2'b11);
        wait_for(0, n);
        chk(delta(4) == 1 && delta(0) == 0, "R8 sectors erased", {delta(4), delta(0)}, 32'h10);

        // R9: suspend while erasing, twice
        snap();
        pulse(K_BLK, sa(7, 0), 0);
        pulse(K_BLK, sa(2, 0), 0);
        wait_for(1, n);
        repeat (2) @(negedge clk);
        pulse(K_SUSP, '0, 0);
        wait_for(2, n);
        chk(n == SUSP && erase_started, "R9 suspend latency", n, SUSP);
        rq = req_cyc;
        repeat (LAT + 4) @(negedge clk);
        chk(req_cyc == rq && suspended, "R9 quiet while suspended", req_cyc - rq, 0);
        pulse(K_RES, '0, 0);
        chk(arr_erase_req && arr_erase_sec == 3'd2 && !suspended, "R9 resume reissues", arr_erase_sec, 2);
        repeat (3) @(negedge clk);
        pulse(K_SUSP, '0, 0);
        wait_for(2, n);
        chk(n == SUSP, "R9 second suspend", n, SUSP);
        pulse(K_RES, '0, 0);
        wait_for(0, n);
        chk(delta(2) == 1 && delta(7) == 1 && !error, "R9 erase completes", {delta(2), delta(7)}, 32'h11);

        // R10: failure on sector 5
        failset = 8'h20;
        snap();
        pulse(K_BLK, sa(5, 0), 0);
        pulse(K_BLK, sa(1, 0), 0);
        wait_for(0, n);
        chk(error && fail_mask == 8'h20, "R10 error latched", fail_mask, 8'h20);
        repeat (5) @(negedge clk);
        pulse(K_BLK, sa(0, 0), 0);
        chk(error && fail_mask == 8'h20 && pending_mask == 0 && !busy, "R10 error holds", {error, pending_mask}, 32'h100);
        pulse(K_RST, '0, 0);
        wait_for(0, n);
        chk(n == ABRT && !error && fail_mask == 0, "R10 reset clears", n, ABRT);
        failset = 8'h00;

        // R11: reset mid-erase
        snap();
        pulse(K_BLK, sa(2, 0), 0);
        wait_for(1, n);
        repeat (2) @(negedge clk);
        pulse(K_RST, '0, 0);
        chk(!arr_erase_req && pending_mask == 0 && busy, "R11 abort silences", {arr_erase_req, busy}, 1);
        wait_for(0, n);
        chk(n == ABRT && delta(2) == 0, "R11 abort length", n, ABRT);
        // R11: reset inside window
        pulse(K_BLK, sa(0, 0), 0);
        pulse(K_RST, '0, 0);
        wait_for(0, n);
        repeat (WIN + LAT) @(negedge clk);
        chk(n == ABRT && delta(0) == 0 && !erase_started, "R11 abort in window", n, ABRT);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule